// File: doc/BRIEF.md
# Double-Data-Rate Separate-Port Burst-of-Two SRAM Core

This block models the memory side of a synchronous SRAM that has one shared address bus and two one-way data buses, one for writes and one for reads. Every access moves exactly two words. Both words of a burst are stored together as a single double-width entry. A controller issues at most one command per K cycle. Write data follows one cycle after its command, as two beats, and each beat has its own active-low byte enables. Read data comes back on both clock phases.

The two clock phases are emulated with one fast clock at twice the K rate. An input flag marks which fast edges are K rising edges; the other edges are K# rising edges. Because a write is committed before any later read reaches its output edge, a read issued in the cycle right after a write to the same address returns the freshly merged data without an extra bypass path.

Top module: `sio_sram`

## Requirements
- R1: Commands (`ld_ni`, `rw_i`, `addr_i`) are sampled only on fast edges where `kedge_i` is 1 (K edges). A load presented on a K# edge (`kedge_i` = 0) starts nothing.
- R2: When `ld_ni` is 1 at a K edge, `rw_i` and `addr_i` are ignored and no operation starts. A write or read already accepted still completes.
- R3: A write accepted at K edge E takes its first beat (`d_i`, `bw_ni`) at the next K edge, E+2. It takes its second beat at the following K# edge, E+3.
- R4: `bw_ni` is active low and is evaluated separately for each beat. Bit i covers `d_i[i*LANE_W +: LANE_W]`. A lane whose enable is 1 keeps its stored value.
- R5: A burst is held as one entry: beat one in the low half and beat two in the high half. A read returns the low half first and the high half second.
- R6: For a read accepted at K edge E, `q_o` shows the first word after the K# edge E+3 and the second word after the K edge E+4, with `q_valid_o` high for both beats.
- R7: A read accepted one K cycle after a write to the same address returns the newly written data, merged per lane with the previous contents.
- R8: `q_o` is high impedance and `q_valid_o` is 0 whenever no read beat is being driven, including during and right after reset.
- R9: Reads on consecutive K cycles produce an unbroken stream of beats. Writes on consecutive K cycles each commit their own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, two edges per K cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| kedge_i | input | 1 | 1 on K rising edges, 0 on K# rising edges |
| ld_ni | input | 1 | Load, active low; starts an operation |
| rw_i | input | 1 | 1 selects read, 0 selects write |
| addr_i | input | AW | Burst address |
| d_i | input | W | Write data beat |
| bw_ni | input | LANES | Per-lane write enables, active low |
| q_o | output | W | Read data beat, high impedance when idle |
| q_valid_o | output | 1 | Read beat present on q_o |

## Verification
A read accepted at K edge E has its first word due 3 fast edges later and its second word due 4 edges later. When the driver issues a read, it records the absolute edge number at which each beat is due, using a reference memory that already holds every earlier write. The monitor samples at the falling edge. It requires `q_valid_o` to be high exactly at those due edges and low everywhere else, so a beat that is early, late, missing or extra fails. Write beats are driven one and 1.5 K cycles after their command, and each takes effect in the reference at the point where it commits.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2
  } sio_cmd_e;
endpackage

// File: rtl/sio_cmd_decode.sv
module sio_cmd_decode
  import sio_pkg::*;
(
  input  logic     kedge_i,
  input  logic     ld_ni,
  input  logic     rw_i,
  output sio_cmd_e cmd_o
);
  always_comb begin
    cmd_o = CMD_NOP;
    if (kedge_i && !ld_ni) cmd_o = rw_i ? CMD_RD : CMD_WR;
  end
endmodule

// File: rtl/sio_write_path.sv
module sio_write_path
  import sio_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int W     = LANES * LANE_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               kedge_i,
  input  sio_cmd_e           cmd_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [W-1:0]       d_i,
  input  logic [LANES-1:0]   bw_ni,
  output logic               commit_o,
  output logic [AW-1:0]      commit_addr_o,
  output logic [2*W-1:0]     commit_data_o,
  output logic [2*LANES-1:0] commit_be_o
);
  logic             pend_q, act_q;
  logic [AW-1:0]    pend_addr_q, act_addr_q;
  logic [W-1:0]     b0_data_q;
  logic [LANES-1:0] b0_be_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      act_q       <= 1'b0;
      pend_addr_q <= '0;
      act_addr_q  <= '0;
      b0_data_q   <= '0;
      b0_be_q     <= '0;
    end else if (kedge_i) begin
      pend_q      <= (cmd_i == CMD_WR);
      pend_addr_q <= addr_i;
      act_q       <= pend_q;
      if (pend_q) begin
        act_addr_q <= pend_addr_q;
        b0_data_q  <= d_i;
        b0_be_q    <= ~bw_ni;
      end
    end else begin
      act_q <= 1'b0;
    end
  end

  // second beat is used straight from the pins on the K# edge
  assign commit_o      = act_q && !kedge_i;
  assign commit_addr_o = act_addr_q;
  assign commit_data_o = {d_i, b0_data_q};
  assign commit_be_o   = {~bw_ni, b0_be_q};
endmodule

// File: rtl/sio_array.sv
module sio_array #(
  parameter int DEPTH  = 64,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int AW    = $clog2(DEPTH),
  localparam int W     = LANES * LANE_W,
  localparam int NL    = 2 * LANES
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [2*W-1:0] wdata_i,
  input  logic [NL-1:0] wbe_i,
  input  logic [AW-1:0] raddr_i,
  output logic [2*W-1:0] rdata_o
);
  logic [2*W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int i = 0; i < NL; i++) begin
        if (wbe_i[i]) mem_q[waddr_i][i*LANE_W +: LANE_W] <= wdata_i[i*LANE_W +: LANE_W];
      end
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/sio_read_path.sv
module sio_read_path
  import sio_pkg::*;
#(
  parameter int AW = 6,
  parameter int W  = 36
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           kedge_i,
  input  sio_cmd_e       cmd_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [2*W-1:0] rdata_i,
  output logic [AW-1:0]  raddr_o,
  output logic [W-1:0]   q_o,
  output logic           vld_o
);
  logic          pend_q, act_q, beat1_q;
  logic [AW-1:0] pend_addr_q, act_addr_q;
  logic [W-1:0]  hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      act_q       <= 1'b0;
      beat1_q     <= 1'b0;
      pend_addr_q <= '0;
      act_addr_q  <= '0;
      hold_q      <= '0;
      q_o         <= '0;
      vld_o       <= 1'b0;
    end else if (kedge_i) begin
      pend_q      <= (cmd_i == CMD_RD);
      pend_addr_q <= addr_i;
      act_q       <= pend_q;
      act_addr_q  <= pend_addr_q;
      beat1_q     <= 1'b0;
      vld_o       <= beat1_q;
      if (beat1_q) q_o <= hold_q;
    end else begin
      act_q   <= 1'b0;
      beat1_q <= act_q;
      vld_o   <= act_q;
      if (act_q) begin
        // array is read at the K# output edge, after any earlier commit
        q_o    <= rdata_i[W-1:0];
        hold_q <= rdata_i[2*W-1:W];
      end
    end
  end

  assign raddr_o = act_addr_q;
endmodule

// File: rtl/sio_sram.sv
module sio_sram
  import sio_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int AW    = $clog2(DEPTH),
  localparam int W     = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             kedge_i,
  input  logic             ld_ni,
  input  logic             rw_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [W-1:0]     d_i,
  input  logic [LANES-1:0] bw_ni,
  output logic [W-1:0]     q_o,
  output logic             q_valid_o
);
  sio_cmd_e               cmd;
  logic                   wr_commit;
  logic [AW-1:0]          wr_addr, rd_addr;
  logic [2*W-1:0]         wr_data, rd_data;
  logic [2*LANES-1:0]     wr_be;
  logic [W-1:0]           q_reg;
  logic                   q_vld;

  sio_cmd_decode u_dec (
    .kedge_i (kedge_i),
    .ld_ni   (ld_ni),
    .rw_i    (rw_i),
    .cmd_o   (cmd)
  );

  sio_write_path #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_wr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .kedge_i       (kedge_i),
    .cmd_i         (cmd),
    .addr_i        (addr_i),
    .d_i           (d_i),
    .bw_ni         (bw_ni),
    .commit_o      (wr_commit),
    .commit_addr_o (wr_addr),
    .commit_data_o (wr_data),
    .commit_be_o   (wr_be)
  );

  sio_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (wr_commit),
    .waddr_i (wr_addr),
    .wdata_i (wr_data),
    .wbe_i   (wr_be),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  sio_read_path #(.AW(AW), .W(W)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .kedge_i (kedge_i),
    .cmd_i   (cmd),
    .addr_i  (addr_i),
    .rdata_i (rd_data),
    .raddr_o (rd_addr),
    .q_o     (q_reg),
    .vld_o   (q_vld)
  );

  assign q_o       = q_vld ? q_reg : {W{1'bz}};
  assign q_valid_o = q_vld;
endmodule

// File: rtl/sio_sram_chk.sv
module sio_sram_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic kedge_i,
  input logic ld_ni,
  input logic rw_i,
  input logic q_valid_o,
  input logic wr_commit
);
  // K and K# edges must alternate
  p_phase_alt_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kedge_i |=> !kedge_i);
  p_phase_alt2_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !kedge_i |=> kedge_i);

  // a commit is always caused by a write load three edges earlier
  p_commit_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit |-> $past(kedge_i && !ld_ni && !rw_i, 3));

  // commit lands on a K# edge
  p_commit_phase_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit |-> !kedge_i);

  p_read_first_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kedge_i && !ld_ni && rw_i) |=> ##3 q_valid_o);
  p_read_second_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kedge_i && !ld_ni && rw_i) |=> ##4 q_valid_o);

  // a burst starts on a K# edge and always carries two beats
  p_start_phase_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_valid_o) |-> !$past(kedge_i));
  p_two_beats_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(q_valid_o) |=> q_valid_o);

  always @(posedge clk_i) begin
    if (!rst_ni) p_reset_idle_r8: assert (!q_valid_o);
  end
endmodule

bind sio_sram sio_sram_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .kedge_i   (kedge_i),
  .ld_ni     (ld_ni),
  .rw_i      (rw_i),
  .q_valid_o (q_valid_o),
  .wr_commit (wr_commit)
);

// File: tb/sio_sram_tb_top.sv
module sio_sram_tb_top;
  localparam int DEPTH  = 64;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int AW     = $clog2(DEPTH);
  localparam int W      = LANES * LANE_W;

  typedef struct {
    logic [W-1:0] data;
    int           due;
    string        tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             kedge = 1'b0;
  logic             ld_n = 1'b1;
  logic             rw = 1'b1;
  logic [AW-1:0]    addr = '0;
  logic [W-1:0]     d = '0;
  logic [LANES-1:0] bw_n = '1;
  logic [W-1:0]     q;
  logic             q_valid;

  int checks = 0;
  int errors = 0;
  int ecount = 0;
  bit done = 1'b0;
  bit ghost = 1'b0;

  exp_t exp_q[$];
  logic [2*W-1:0] ref_mem [DEPTH];

  bit               prev_wr = 1'b0;
  logic [AW-1:0]    prev_addr = '0;
  logic [2*W-1:0]   prev_data = '0;
  logic [2*LANES-1:0] prev_bw = '1;

  always #2.5 clk = ~clk;

  sio_sram #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .kedge_i   (kedge),
    .ld_ni     (ld_n),
    .rw_i      (rw),
    .addr_i    (addr),
    .d_i       (d),
    .bw_ni     (bw_n),
    .q_o       (q),
    .q_valid_o (q_valid)
  );

  always @(posedge clk) if (rst_ni) ecount <= ecount + 1;

  task automatic fail(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
    errors++;
    $display("FAIL %s actual %h expected %h (edge %0d)", tag, act, expv, ecount);
  endtask

  function automatic logic [2*W-1:0] mkword(input int a, input int s);
    return {W'(a * 32'h1357 + s * 32'h2468ace), W'((a * 32'h9bdf1) ^ (s * 32'h0f0f0f))};
  endfunction

  // one K cycle: K edge then K# edge; data pins carry the previous write's beats
  task automatic kcycle(input logic l, input logic r, input int a,
                        input logic [2*W-1:0] wd, input logic [2*LANES-1:0] wbn);
    int ce;
    kedge = 1'b1; ld_n = l; rw = r; addr = AW'(a);
    d    = prev_wr ? prev_data[W-1:0] : {W{1'b1}};
    bw_n = prev_wr ? prev_bw[LANES-1:0] : '0;
    ce = ecount + 1;
    if (prev_wr) begin
      for (int i = 0; i < 2*LANES; i++)
        if (!prev_bw[i]) ref_mem[prev_addr][i*LANE_W +: LANE_W] = prev_data[i*LANE_W +: LANE_W];
    end
    if (!l && r) begin
      exp_q.push_back('{ref_mem[a][W-1:0], ce + 3, "R5 R6 R7 beat0"});
      exp_q.push_back('{ref_mem[a][2*W-1:W], ce + 4, "R5 R6 R7 beat1"});
    end
    @(negedge clk);
    kedge = 1'b0; ld_n = ghost ? 1'b0 : 1'b1; rw = 1'b1; addr = AW'(a);
    d    = prev_wr ? prev_data[2*W-1:W] : {W{1'b1}};
    bw_n = prev_wr ? prev_bw[2*LANES-1:LANES] : '0;
    @(negedge clk);
    prev_wr   = !l && !r;
    prev_addr = AW'(a);
    prev_data = wd;
    prev_bw   = wbn;
  endtask

  task automatic nop();
    kcycle(1'b1, 1'b1, 0, '0, '1);
  endtask
  task automatic rd(input int a);
    kcycle(1'b0, 1'b1, a, '0, '1);
  endtask
  task automatic wr(input int a, input logic [2*W-1:0] wd, input logic [2*LANES-1:0] wbn);
    kcycle(1'b0, 1'b0, a, wd, wbn);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (q_valid) begin
        checks++;
        if (exp_q.size() == 0) fail("R2 R8 unexpected beat", q, '0);
        else begin
          if (exp_q[0].due != ecount) fail({exp_q[0].tag, " R6 timing"}, W'(ecount), W'(exp_q[0].due));
          else if (q !== exp_q[0].data) fail(exp_q[0].tag, q, exp_q[0].data);
          void'(exp_q.pop_front());
        end
      end else if (exp_q.size() != 0 && exp_q[0].due <= ecount) begin
        checks++;
        fail({exp_q[0].tag, " R6 missing beat"}, '0, exp_q[0].data);
        void'(exp_q.pop_front());
      end
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (q_valid !== 1'b0) fail("R8 reset idle", W'(q_valid), '0);
    rst_ni = 1'b1;

    // R9 R3: back-to-back full writes
    for (int a = 0; a < 8; a++) wr(a, mkword(a, 1), '0);
    nop();
    checks++;
    if (q_valid !== 1'b0) fail("R8 idle after writes", W'(q_valid), '0);
    // R9 R5: consecutive reads stream
    rd(1); rd(2); rd(7); nop(); rd(0); nop();
    // R4 R7: masked write, read in the next cycle
    wr(3, mkword(3, 9), 8'b1010_0101);
    rd(3);
    nop();
    // R2: load high with write select, data ignored
    kcycle(1'b1, 1'b0, 4, mkword(4, 5), '0);
    nop();
    rd(4);
    // R2: load high with read select gives no beats
    kcycle(1'b1, 1'b1, 5, '0, '1);
    nop(); nop();
    // R1: loads on K# edges only
    ghost = 1'b1; nop(); nop(); ghost = 1'b0;
    nop(); nop();
    // NOP, read, read, write, write, read, NOP
    nop(); rd(5); rd(0); wr(5, mkword(5, 3), 8'b0011_1100); wr(6, mkword(6, 4), 8'b1111_0000);
    rd(5); nop();
    rd(6);
    // R7: write-then-read with all lanes masked on beat two
    wr(2, mkword(2, 7), 8'b1111_0110); rd(2);
    // R2: write completes through idle cycles
    wr(7, mkword(7, 8), '0); nop(); nop(); rd(7);
    repeat (6) nop();
    checks++;
    if (exp_q.size() != 0) fail("R6 beats left undelivered", W'(exp_q.size()), '0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fail("watchdog R6", '0, '0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule